// File: doc/BRIEF.md
# Phased Tag-First Three-Way Cache Lookup Controller

This block sits in front of a three-way set-associative cache. It splits each lookup into two phases to save energy. In the first phase it reads the tag and valid state of every way of the addressed set and compares each one with the tag of the request. Only when the matching way is known does it start the second phase. That phase reads the data bank of that single way. A lookup that matches nothing reads no data bank at all. The cost is one extra cycle of latency over a cache that reads tags and data together.

On a miss the controller raises a refill request that carries the line address. It holds off new requests until the refill side answers with a single-cycle acknowledge and the line data. It then installs the line in a victim way and returns that data with the hit flag low. Each set has its own round-robin pointer that picks the victim. A running count of data-bank reads is brought out, so that the energy claim can be checked from outside the block.

Top module: `phased_cache_ctrl`

## Requirements
- R1: In the cycle after a request is accepted, all three tag-read enables are high and every data-read enable is low.
- R2: On a hit, in the cycle after the tag phase, exactly one data-read enable is high. It is the one of the way that holds the tag (bit w of `data_rd_en` selects way w). At most one way can match in a set.
- R3: On a miss, no data-read enable is raised at any point of the lookup or the refill.
- R4: A hit response appears exactly two cycles after the accepting clock edge: `rsp_valid` pulses for one cycle with `rsp_hit` high and the word last written for that address.
- R5: On a miss, `refill_req` is raised with `refill_addr` equal to the request address, and `req_ready` stays low until `refill_ack`. In the cycle after the acknowledge, `rsp_valid` pulses with `rsp_hit` low and `rsp_data` equal to `refill_data`. Later lookups of that address hit.
- R6: Each set picks its victim way by its own pointer, which starts at way 0 after reset and steps 0, 1, 2, 0 with each refill of that set. Refills of other sets do not move it.
- R7: After reset every line is invalid, so a lookup misses even when its tag equals the cleared tag contents.
- R8: `bank_rd_cnt` is zero after reset and grows by the number of data-read enables raised. That makes one per hit and none per miss.
- R9: After reset, `req_ready` is high, and `rsp_valid`, `refill_req` and all read enables are low. `req_ready` is high only while no lookup is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Word address; low SET_W bits pick the set, the rest are the tag |
| req_ready | output | 1 | Controller idle, request taken at this edge if valid |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from a hit (1) or a refill (0) |
| rsp_data | output | DATA_W | Response word |
| tag_rd_en | output | WAYS | Per-way tag array read enable |
| data_rd_en | output | WAYS | Per-way data bank read enable |
| refill_req | output | 1 | Refill wanted for `refill_addr` |
| refill_addr | output | ADDR_W | Address of the missing line |
| refill_ack | input | 1 | Refill data present this cycle |
| refill_data | input | DATA_W | Line data delivered with the acknowledge |
| bank_rd_cnt | output | CNT_W | Count of data bank reads since reset |

## Verification
The bench starts with a lookup of tag zero right after reset. A design that ignored the valid bit would report a false hit there. It then fills one set past three lines and checks which way later hits. A shared victim pointer, a pointer that skipped way 2, or a pointer that failed to wrap would move the hit to a different enable bit or turn an expected hit into a miss. In every lookup it samples the enables phase by phase. A controller that read data alongside the tags, read all banks, or read a bank on a miss shows up in the enables or in the bank-read count. It also holds the acknowledge back for several cycles, where a controller that dropped `refill_req` or raised `req_ready` early is caught.

// File: rtl/phc_pkg.sv
// Shared types for the phased cache lookup controller.
// Assumes nothing beyond a single clock domain.
package phc_pkg;
    // Lookup phases: idle, tag compare, single data bank read, refill wait
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TAG  = 2'd1,
        PH_DATA = 2'd2,
        PH_FILL = 2'd3
    } phase_e;
endpackage

// File: rtl/phc_tag_way.sv
// Tag and valid store for one way, one entry per set.
// Reads are combinational and return zero unless enabled, so an idle
// way shows no activity. Only the valid bits are reset.
module phc_tag_way #(
    parameter int SET_W = 2,
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];

    // Valid bits: cleared by reset, set when a line is installed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_set] <= 1'b1;
        end
    end

    // Tag storage: written on install, not reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set] <= wr_tag;
        end
    end

    // Gated read port
    always_comb begin
        rd_vld = rd_en & vld_q[rd_set];
        rd_tag = rd_en ? tag_q[rd_set] : '0;
    end
endmodule

// File: rtl/phc_data_way.sv
// Data bank for one way, one word per set. The read port returns zero
// unless enabled, which models a bank that is not accessed.
module phc_data_way #(
    parameter int SET_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [SET_W-1:0]  rd_set,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << SET_W;

    logic [DATA_W-1:0] mem_q [SETS];

    // Word storage written on install
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_set] <= wr_data;
        end
    end

    // Gated read port
    always_comb begin
        rd_data = rd_en ? mem_q[rd_set] : '0;
    end
endmodule

// File: rtl/phc_victim_rr.sv
// Per-set round-robin victim pointer. Each set steps through ways
// 0..WAYS-1 and wraps; only the set being refilled advances.
module phc_victim_rr #(
    parameter int SET_W = 2,
    parameter int WAYS  = 3,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             advance,
    output logic [WAY_W-1:0] victim
);
    localparam int SETS = 1 << SET_W;
    localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] ptr_q [SETS];

    // Pointer update: reset to way 0, wrap after the last way
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                ptr_q[s] <= '0;
            end
        end else if (advance) begin
            ptr_q[set_idx] <= (ptr_q[set_idx] == LAST) ? '0 : ptr_q[set_idx] + 1'b1;
        end
    end

    // Current victim of the addressed set
    assign victim = ptr_q[set_idx];
endmodule

// File: rtl/phased_cache_ctrl.sv
// Phased tag-first lookup controller for a WAYS-way set-associative
// cache holding one DATA_W word per line. Phase 1 reads every tag of the
// set; phase 2 reads only the matching data bank. A miss waits for a
// refill handshake, installs the line in the round-robin victim way and
// returns the refilled word. One lookup is in flight at a time.
module phased_cache_ctrl
    import phc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int SET_W  = 2,
    parameter int WAYS   = 3,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic [WAYS-1:0]   tag_rd_en,
    output logic [WAYS-1:0]   data_rd_en,
    output logic              refill_req,
    output logic [ADDR_W-1:0] refill_addr,
    input  logic              refill_ack,
    input  logic [DATA_W-1:0] refill_data,
    output logic [CNT_W-1:0]  bank_rd_cnt
);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    phase_e            phase_q;
    logic [SET_W-1:0]  set_q;
    logic [TAG_W-1:0]  tag_q;
    logic [WAY_W-1:0]  hit_way_q;
    logic              rsp_valid_q;
    logic              rsp_hit_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [WAYS-1:0]   way_vld;
    logic [TAG_W-1:0]  way_tag [WAYS];
    logic [DATA_W-1:0] way_data [WAYS];
    logic [WAYS-1:0]   way_hit;
    logic              any_hit;
    logic [WAY_W-1:0]  hit_idx;
    logic [DATA_W-1:0] bank_word;
    logic [WAY_W-1:0]  victim;
    logic              fill_we;
    logic [CNT_W-1:0]  rd_inc;

    assign fill_we = (phase_q == PH_FILL) && refill_ack;

    // Per-way tag and data stores
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic wr_this;
        assign wr_this = fill_we && (victim == WAY_W'(w));

        phc_tag_way #(.SET_W(SET_W), .TAG_W(TAG_W)) i_tag (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (tag_rd_en[w]),
            .rd_set (set_q),
            .rd_vld (way_vld[w]),
            .rd_tag (way_tag[w]),
            .wr_en  (wr_this),
            .wr_set (set_q),
            .wr_tag (tag_q)
        );

        phc_data_way #(.SET_W(SET_W), .DATA_W(DATA_W)) i_data (
            .clk     (clk),
            .rd_en   (data_rd_en[w]),
            .rd_set  (set_q),
            .rd_data (way_data[w]),
            .wr_en   (wr_this),
            .wr_set  (set_q),
            .wr_data (refill_data)
        );

        assign tag_rd_en[w]  = (phase_q == PH_TAG);
        assign data_rd_en[w] = (phase_q == PH_DATA) && (hit_way_q == WAY_W'(w));
        assign way_hit[w]    = way_vld[w] && (way_tag[w] == tag_q);
    end

    phc_victim_rr #(.SET_W(SET_W), .WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_idx (set_q),
        .advance (fill_we),
        .victim  (victim)
    );

    // Encode the matching way and merge the gated bank outputs
    always_comb begin
        any_hit   = |way_hit;
        hit_idx   = '0;
        bank_word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) hit_idx = WAY_W'(w);
            bank_word = bank_word | way_data[w];
        end
    end

    // Number of banks read this cycle
    always_comb begin
        rd_inc = '0;
        for (int w = 0; w < WAYS; w++) begin
            rd_inc = rd_inc + CNT_W'(data_rd_en[w]);
        end
    end

    // Phase sequencer with request capture and response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            set_q       <= '0;
            tag_q       <= '0;
            hit_way_q   <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        set_q   <= req_addr[SET_W-1:0];
                        tag_q   <= req_addr[ADDR_W-1:SET_W];
                        phase_q <= PH_TAG;
                    end
                end
                PH_TAG: begin
                    hit_way_q <= hit_idx;
                    phase_q   <= any_hit ? PH_DATA : PH_FILL;
                end
                PH_DATA: begin
                    rsp_valid_q <= 1'b1;
                    rsp_hit_q   <= 1'b1;
                    rsp_data_q  <= bank_word;
                    phase_q     <= PH_IDLE;
                end
                PH_FILL: begin
                    if (refill_ack) begin
                        rsp_valid_q <= 1'b1;
                        rsp_hit_q   <= 1'b0;
                        rsp_data_q  <= refill_data;
                        phase_q     <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Data bank read counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + rd_inc;
        end
    end

    assign req_ready   = (phase_q == PH_IDLE);
    assign refill_req  = (phase_q == PH_FILL);
    assign refill_addr = {tag_q, set_q};
    assign rsp_valid   = rsp_valid_q;
    assign rsp_hit     = rsp_hit_q;
    assign rsp_data    = rsp_data_q;
    assign bank_rd_cnt = cnt_q;
endmodule

// File: rtl/phc_ctrl_chk.sv
// Protocol checker for phased_cache_ctrl, attached by bind.
// Watches the phase ordering of tag and data reads and the response timing.
module phc_ctrl_chk #(
    parameter int WAYS = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [WAYS-1:0] tag_rd_en,
    input logic [WAYS-1:0] data_rd_en,
    input logic [WAYS-1:0] way_hit,
    input logic            refill_req,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_hit
);
    // R1
    data_after_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_rd_en) |-> $past(&tag_rd_en));

    // R1
    tags_without_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tag_rd_en) |-> (data_rd_en == '0));

    // R2
    single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_rd_en));

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R3
    miss_no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> (data_rd_en == '0));

    // R4
    hit_rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_rd_en) |=> (rsp_valid && rsp_hit));

    // R5
    refill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> !req_ready);

    // R5
    miss_rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> $past(refill_req));
endmodule

bind phased_cache_ctrl phc_ctrl_chk #(.WAYS(WAYS)) u_phc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tag_rd_en  (tag_rd_en),
    .data_rd_en (data_rd_en),
    .way_hit    (way_hit),
    .refill_req (refill_req),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit)
);

// File: tb/test_phased_cache_ctrl.sv
`timescale 1ns/1ps
module test_phased_cache_ctrl;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int WAYS   = 3;
    localparam int CNT_W  = 16;
    localparam int NVEC   = 19;

    // Entry: {expect_hit, expected hit way, address}; set = addr[1:0]
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 12'h002},  // R7 tag 0 after reset misses; set2 -> way0
        {1'b1, 2'd0, 12'h002},
        {1'b0, 2'd0, 12'h010},  // set0 -> way0
        {1'b1, 2'd0, 12'h010},
        {1'b0, 2'd0, 12'h020},  // set0 -> way1
        {1'b0, 2'd0, 12'h030},  // set0 -> way2
        {1'b1, 2'd0, 12'h010},
        {1'b1, 2'd1, 12'h020},
        {1'b0, 2'd0, 12'h040},  // R6 wrap: way0, evicts 010
        {1'b0, 2'd0, 12'h010},  // way1, evicts 020
        {1'b1, 2'd2, 12'h030},
        {1'b0, 2'd0, 12'h020},  // way2, evicts 030
        {1'b0, 2'd0, 12'h041},  // set1 own pointer -> way0
        {1'b1, 2'd0, 12'h040},
        {1'b0, 2'd0, 12'h030},  // set0 pointer back at way0, evicts 040
        {1'b1, 2'd0, 12'h041},
        {1'b1, 2'd0, 12'h002},
        {1'b1, 2'd1, 12'h010},
        {1'b1, 2'd2, 12'h020}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [DATA_W-1:0] rsp_data;
    logic [WAYS-1:0]   tag_rd_en;
    logic [WAYS-1:0]   data_rd_en;
    logic              refill_req;
    logic [ADDR_W-1:0] refill_addr;
    logic              refill_ack = 1'b0;
    logic [DATA_W-1:0] refill_data = '0;
    logic [CNT_W-1:0]  bank_rd_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phased_cache_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(2), .WAYS(WAYS), .CNT_W(CNT_W)
    ) i_phased_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .tag_rd_en(tag_rd_en), .data_rd_en(data_rd_en),
        .refill_req(refill_req), .refill_addr(refill_addr),
        .refill_ack(refill_ack), .refill_data(refill_data),
        .bank_rd_cnt(bank_rd_cnt)
    );

    function automatic logic [DATA_W-1:0] line_word(input logic [ADDR_W-1:0] a);
        return {~a[3:0], a} ^ 16'h5A3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One lookup from an idle negedge to the response negedge
    task automatic access(input int i);
        logic [ADDR_W-1:0] a;
        logic              exp_hit;
        logic [1:0]        exp_way;
        logic [CNT_W-1:0]  c0;
        a       = VEC[i][11:0];
        exp_way = VEC[i][13:12];
        exp_hit = VEC[i][14];
        c0      = bank_rd_cnt;
        chk(req_ready == 1'b1, "R9", "ready when idle", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag_rd_en == 3'b111 && data_rd_en == 3'b000, "R1", "tag phase enables",
            {tag_rd_en, data_rd_en}, 6'b111000);
        @(negedge clk);
        if (exp_hit) begin
            chk(data_rd_en == (3'b001 << exp_way), "R2", "hit bank enable",
                data_rd_en, 3'b001 << exp_way);
            chk(refill_req == 1'b0, "R2", "no refill on hit", refill_req, 0);
            chk(rsp_valid == 1'b0, "R4", "no early response", rsp_valid, 0);
            @(negedge clk);
            chk(rsp_valid && rsp_hit, "R4", "hit response strobe",
                {rsp_valid, rsp_hit}, 2'b11);
            chk(rsp_data == line_word(a), "R4", "hit data", rsp_data, line_word(a));
            chk(bank_rd_cnt == c0 + 1'b1, "R8", "one bank read per hit",
                bank_rd_cnt, c0 + 1'b1);
        end else begin
            chk(refill_req && refill_addr == a, "R5", "refill request",
                {refill_req, refill_addr}, {1'b1, a});
            chk(data_rd_en == 3'b000, "R3", "no bank on miss", data_rd_en, 0);
            for (int k = 0; k < 3; k++) begin
                req_valid = 1'b1;  // attempted request while busy
                req_addr  = 12'hFFF;
                chk(req_ready == 1'b0 && refill_req == 1'b1 && rsp_valid == 1'b0,
                    "R5", "stall while refilling", {req_ready, refill_req, rsp_valid}, 3'b010);
                @(negedge clk);
            end
            req_valid   = 1'b0;
            refill_ack  = 1'b1;
            refill_data = line_word(a);
            @(negedge clk);
            refill_ack  = 1'b0;
            refill_data = '0;
            chk(rsp_valid && !rsp_hit, "R5", "miss response strobe",
                {rsp_valid, rsp_hit}, 2'b10);
            chk(rsp_data == line_word(a), "R5", "refill data returned",
                rsp_data, line_word(a));
            chk(bank_rd_cnt == c0, "R3", "no bank read count on miss", bank_rd_cnt, c0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && refill_req == 1'b0, "R9",
            "reset outputs", {req_ready, rsp_valid, refill_req}, 3'b100);
        chk(tag_rd_en == '0 && data_rd_en == '0, "R9", "reset enables",
            {tag_rd_en, data_rd_en}, 0);
        chk(bank_rd_cnt == '0, "R8", "reset count", bank_rd_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            access(i);
        end
        // R8 total: one read per expected hit
        chk(bank_rd_cnt == 16'd10, "R8", "total bank reads", bank_rd_cnt, 10);
        // R7 reset clears valid: a line that hit before now misses
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(bank_rd_cnt == '0, "R8", "count cleared by reset", bank_rd_cnt, 0);
        req_valid = 1'b1;
        req_addr  = 12'h010;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(refill_req == 1'b1 && data_rd_en == '0, "R7", "miss after reset",
            {refill_req, data_rd_en}, 4'b1000);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule